// File: doc/BRIEF.md
# Delay-Line Snapshot Hit Encoder

This block sits behind a tapped delay line. A pulse front runs along the line, and a wide snapshot of the line is latched on every fast clock edge. The block turns each newly launched front into one timestamp. First it thins the raw taps down to a shorter vector by keeping every third tap. Next it looks at the first tap in consecutive snapshots to spot the start of a new pulse. It then finds the front nearest the line input and encodes that tap index as a binary fine count.

Each hit is tagged with two values: the fast-clock phase (0 to 3) inside the slow period, and an 11-bit coarse count of slow periods. Hits are grouped into frames of four fast cycles. Each frame becomes one record that a register on the slow clock picks up. The slow clock runs at one quarter of the fast rate, and its rising edges coincide with fast rising edges. The delay chain itself is modelled by the `raw_taps` input. Calibration of the fine count is not part of this block.

Top module: `hit_encoder_top`

## Requirements
- R1: While `rst` is high (synchronous, sampled in both clock domains), `hit_valid` is 0 and all counters are cleared. The first frame after reset carries coarse value 0.
- R2: Reduced tap i equals `raw_taps[3*i]`. No other raw tap has any effect on the outputs.
- R3: Snapshot n raises a hit only when reduced tap 0 was 0 in snapshot n-1 and is 1 in snapshot n. Snapshot -1 counts as all zeros. A pulse held high over many samples gives one hit.
- R4: The fine count is the lowest i where reduced tap i is 1 and tap i+1 is 0, with tap 64 counted as 0. An all-ones snapshot gives 63. Transitions further from the input are ignored.
- R5: The phase field equals n mod 4. Here n counts fast edges from e0, the first edge with `rst` low, and snapshot n is the value on `raw_taps` at edge e_n.
- R6: The coarse field equals floor(n/4) mod 2048 and wraps from 2047 to 0.
- R7: Frame F covers snapshots 4F to 4F+3 and yields at most one record. If several hits fall in the frame, the earliest is reported and the others are dropped.
- R8: Slow rising edges fall on the fast edges e_{4k}. The record of frame F is on the outputs for exactly the one slow cycle that starts at e_{4F+8}.
- R9: A frame with no hit shows `hit_valid` = 0 during its slow cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Snapshot clock |
| clk_slow | input | 1 | Readout clock, quarter rate, edges aligned to clk_fast |
| rst | input | 1 | Synchronous active-high reset for both domains |
| raw_taps | input | 192 | Latched delay-line snapshot, tap 0 nearest the input |
| hit_valid | output | 1 | Record of the current slow cycle holds a hit |
| hit_fine | output | 6 | Fine tap index of the front |
| hit_phase | output | 2 | Fast phase of the hit inside the slow period |
| hit_coarse | output | 11 | Slow-period count of the hit |

## Verification
Snapshot n enters the first register at e_n. Its hit decision is folded into the frame accumulator at e_{n+1}. The frame register is loaded at e_{4F+4}, and the slow register copies it at e_{4F+8}. The bench therefore counts slow rising edges from e0 and, after edge m, expects the record of frame m-2, with no record for m below 2. It samples 7 ns into each slow cycle, well clear of both clock edges. Every expected record is rebuilt from a deterministic per-cycle pattern function, so nothing depends on the design's latency except the R8 formula.

// File: rtl/hit_encoder_pkg.sv
package hit_encoder_pkg;
    localparam int RAW_TAPS_DEF  = 192;
    localparam int FINE_TAPS_DEF = 64;
    localparam int COARSE_W_DEF  = 11;
    localparam int PHASES_DEF    = 4;
endpackage

// File: rtl/tap_thinner.sv
module tap_thinner #(
    parameter int RAW_TAPS  = hit_encoder_pkg::RAW_TAPS_DEF,
    parameter int FINE_TAPS = hit_encoder_pkg::FINE_TAPS_DEF
) (
    input  logic [RAW_TAPS-1:0]  raw_taps,
    output logic [FINE_TAPS-1:0] thin_taps
);
    localparam int RATIO = RAW_TAPS / FINE_TAPS;

    for (genvar g = 0; g < FINE_TAPS; g++) begin : g_pick
        assign thin_taps[g] = raw_taps[g*RATIO];
    end

    logic unused_taps;
    assign unused_taps = ^raw_taps;
endmodule

// File: rtl/front_locator.sv
module front_locator #(
    parameter int TAPS  = hit_encoder_pkg::FINE_TAPS_DEF,
    localparam int IDX_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]  cur_taps,
    input  logic             prev_first,
    output logic             new_hit,
    output logic [IDX_W-1:0] front_idx
);
    logic [TAPS-1:0] mark;

    always_comb begin
        mark      = cur_taps & ~(cur_taps >> 1);
        new_hit   = cur_taps[0] & ~prev_first;
        front_idx = '0;
        for (int i = TAPS - 1; i >= 0; i--) begin
            if (mark[i]) front_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/frame_packer.sv
module frame_packer #(
    parameter int TAPS     = hit_encoder_pkg::FINE_TAPS_DEF,
    parameter int COARSE_W = hit_encoder_pkg::COARSE_W_DEF,
    parameter int PHASES   = hit_encoder_pkg::PHASES_DEF,
    localparam int IDX_W   = $clog2(TAPS),
    localparam int PH_W    = $clog2(PHASES)
) (
    input  logic                clk_fast,
    input  logic                rst,
    input  logic [TAPS-1:0]     thin_taps,
    output logic [TAPS-1:0]     stage_taps,
    output logic                stage_prev_first,
    input  logic                new_hit,
    input  logic [IDX_W-1:0]    front_idx,
    output logic                frame_valid,
    output logic [IDX_W-1:0]    frame_fine,
    output logic [PH_W-1:0]     frame_phase,
    output logic [COARSE_W-1:0] frame_coarse
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    typedef struct packed {
        logic                valid;
        logic [IDX_W-1:0]    fine;
        logic [PH_W-1:0]     phase;
        logic [COARSE_W-1:0] coarse;
    } rec_t;

    typedef struct packed {
        logic [PH_W-1:0]     ph;
        logic [COARSE_W-1:0] coarse;
        logic                s1_vld;
        logic [TAPS-1:0]     s1_taps;
        logic                s1_prev0;
        logic [PH_W-1:0]     s1_ph;
        logic [COARSE_W-1:0] s1_coarse;
        rec_t                acc;
        rec_t                frame;
    } state_t;

    state_t st_d, st_q;
    rec_t   merged;

    always_comb begin
        st_d = st_q;
        // free-running phase and coarse counters
        if (st_q.ph == LAST_PH) begin
            st_d.ph     = '0;
            st_d.coarse = st_q.coarse + COARSE_W'(1);
        end else begin
            st_d.ph     = st_q.ph + PH_W'(1);
        end
        // stage 1: capture the snapshot and its time tag
        st_d.s1_vld    = 1'b1;
        st_d.s1_taps   = thin_taps;
        st_d.s1_prev0  = st_q.s1_taps[0];
        st_d.s1_ph     = st_q.ph;
        st_d.s1_coarse = st_q.coarse;
        // stage 2: keep the earliest hit of the frame
        merged = st_q.acc;
        if (st_q.s1_vld && new_hit && !st_q.acc.valid) begin
            merged.valid  = 1'b1;
            merged.fine   = front_idx;
            merged.phase  = st_q.s1_ph;
            merged.coarse = st_q.s1_coarse;
        end
        if (st_q.s1_vld && st_q.s1_ph == LAST_PH) begin
            st_d.frame = merged;
            st_d.acc   = '0;
        end else begin
            st_d.acc   = merged;
        end
    end

    always_ff @(posedge clk_fast) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stage_taps       = st_q.s1_taps;
    assign stage_prev_first = st_q.s1_prev0;
    assign frame_valid      = st_q.frame.valid;
    assign frame_fine       = st_q.frame.fine;
    assign frame_phase      = st_q.frame.phase;
    assign frame_coarse     = st_q.frame.coarse;

    // R3
    no_back_to_back_hit_chk: assert property (@(posedge clk_fast) disable iff (rst)
        (st_q.s1_vld && new_hit) |=> !new_hit);

    // R6
    coarse_step_chk: assert property (@(posedge clk_fast) disable iff (rst)
        (st_q.ph == LAST_PH) |=> (st_q.ph == '0 && st_q.coarse == $past(st_q.coarse) + COARSE_W'(1)));

    // R7
    first_hit_kept_chk: assert property (@(posedge clk_fast) disable iff (rst)
        (st_q.acc.valid && st_q.s1_vld && st_q.s1_ph != LAST_PH) |=> (st_q.acc.valid && $stable(st_q.acc)));

    // R8
    frame_hold_chk: assert property (@(posedge clk_fast) disable iff (rst)
        (st_q.s1_vld && st_q.s1_ph != LAST_PH) |=> $stable(st_q.frame));
endmodule

// File: rtl/hit_encoder_top.sv
module hit_encoder_top #(
    parameter int RAW_TAPS  = hit_encoder_pkg::RAW_TAPS_DEF,
    parameter int FINE_TAPS = hit_encoder_pkg::FINE_TAPS_DEF,
    parameter int COARSE_W  = hit_encoder_pkg::COARSE_W_DEF,
    parameter int PHASES    = hit_encoder_pkg::PHASES_DEF,
    localparam int IDX_W    = $clog2(FINE_TAPS),
    localparam int PH_W     = $clog2(PHASES)
) (
    input  logic                clk_fast,
    input  logic                clk_slow,
    input  logic                rst,
    input  logic [RAW_TAPS-1:0] raw_taps,
    output logic                hit_valid,
    output logic [IDX_W-1:0]    hit_fine,
    output logic [PH_W-1:0]     hit_phase,
    output logic [COARSE_W-1:0] hit_coarse
);
    typedef struct packed {
        logic                valid;
        logic [IDX_W-1:0]    fine;
        logic [PH_W-1:0]     phase;
        logic [COARSE_W-1:0] coarse;
    } out_t;

    logic [FINE_TAPS-1:0] thin_taps;
    logic [FINE_TAPS-1:0] stage_taps;
    logic                 stage_prev_first;
    logic                 new_hit;
    logic [IDX_W-1:0]     front_idx;
    logic                 frame_valid;
    logic [IDX_W-1:0]     frame_fine;
    logic [PH_W-1:0]      frame_phase;
    logic [COARSE_W-1:0]  frame_coarse;

    tap_thinner #(.RAW_TAPS(RAW_TAPS), .FINE_TAPS(FINE_TAPS)) u_thin (
        .raw_taps  (raw_taps),
        .thin_taps (thin_taps)
    );

    front_locator #(.TAPS(FINE_TAPS)) u_front (
        .cur_taps   (stage_taps),
        .prev_first (stage_prev_first),
        .new_hit    (new_hit),
        .front_idx  (front_idx)
    );

    frame_packer #(.TAPS(FINE_TAPS), .COARSE_W(COARSE_W), .PHASES(PHASES)) u_pack (
        .clk_fast         (clk_fast),
        .rst              (rst),
        .thin_taps        (thin_taps),
        .stage_taps       (stage_taps),
        .stage_prev_first (stage_prev_first),
        .new_hit          (new_hit),
        .front_idx        (front_idx),
        .frame_valid      (frame_valid),
        .frame_fine       (frame_fine),
        .frame_phase      (frame_phase),
        .frame_coarse     (frame_coarse)
    );

    out_t out_d, out_q;

    always_comb begin
        out_d.valid  = frame_valid;
        out_d.fine   = frame_fine;
        out_d.phase  = frame_phase;
        out_d.coarse = frame_coarse;
    end

    always_ff @(posedge clk_slow) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign hit_valid  = out_q.valid;
    assign hit_fine   = out_q.fine;
    assign hit_phase  = out_q.phase;
    assign hit_coarse = out_q.coarse;
endmodule

// File: tb/hit_encoder_top_tb.sv
`timescale 1ns/1ps
module hit_encoder_top_tb;
    localparam int NCYC = 9216;
    localparam int NFRM = NCYC / 4;

    logic         clk_fast = 1'b0;
    logic         clk_slow = 1'b0;
    logic         rst = 1'b1;
    logic [191:0] raw_taps = '0;
    logic         hit_valid;
    logic [5:0]   hit_fine;
    logic [1:0]   hit_phase;
    logic [10:0]  hit_coarse;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    hit_encoder_top u_dut (
        .clk_fast(clk_fast), .clk_slow(clk_slow), .rst(rst), .raw_taps(raw_taps),
        .hit_valid(hit_valid), .hit_fine(hit_fine), .hit_phase(hit_phase), .hit_coarse(hit_coarse)
    );

    // 200 MHz fast clock, slow clock rising on every fourth fast rising edge
    initial begin
        int k;
        k = 0;
        forever begin
            clk_fast = 1'b1;
            if (k % 4 == 0) clk_slow = 1'b1;
            if (k % 4 == 2) clk_slow = 1'b0;
            #2.5;
            clk_fast = 1'b0;
            #2.5;
            k++;
        end
    end

    function automatic logic [31:0] mix(input int n);
        logic [31:0] x;
        x = 32'(n) * 32'h9E3779B1 + 32'h7F4A7C15;
        x = x ^ (x >> 15);
        x = x * 32'h2C1B3C6D;
        x = x ^ (x >> 12);
        return x;
    endfunction

    // reduced snapshot for cycle n
    function automatic logic [63:0] pat(input int n);
        logic [31:0] h;
        logic [63:0] c;
        int len;
        if (n < 0) return '0;
        if (n >= 100 && n < 120) return 64'h3FF;
        if (n >= 200 && n < 456) begin
            if (n % 4 != 1) return '0;
            len = (n - 200) / 4 + 1;
            return (len == 64) ? '1 : ((64'd1 << len) - 64'd1);
        end
        h = mix(n);
        c = '0;
        if (h[0]) begin
            len = int'(h[7:2]) + 1;
            c = (len == 64) ? '1 : ((64'd1 << len) - 64'd1);
            if (h[8] && len <= 60) c = c | (64'b11 << (len + 1));
        end else if (h[1]) begin
            c = 64'hFF << 40;
        end
        return c;
    endfunction

    function automatic logic [191:0] raw_of(input int n);
        logic [191:0] r;
        logic [63:0]  c;
        r = {mix(n+7), mix(n+13), mix(n+29), mix(n+31), mix(n+47), mix(n+53)};
        c = pat(n);
        for (int i = 0; i < 64; i++) r[3*i] = c[i];
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_frame(input int f, output bit v, output int fine, output int ph, output int co);
        logic [63:0] c, mk;
        v = 1'b0; fine = 0; ph = 0; co = f % 2048;
        for (int j = 0; j < 4; j++) begin
            int n;
            n = 4*f + j;
            c = pat(n);
            if (!v && c[0] && !pat(n-1)[0]) begin
                v = 1'b1;
                ph = j;
                mk = c & ~(c >> 1);
                for (int i = 63; i >= 0; i--) if (mk[i]) fine = i;
            end
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge clk_fast);
        // R1: outputs idle during reset
        chk("R1 valid in reset", int'(hit_valid), 0);
        @(posedge clk_slow);
        repeat (4) @(negedge clk_fast);
        chk("R1 valid in reset", int'(hit_valid), 0);
        rst = 1'b0;
        raw_taps = raw_of(0);
        fork
            begin
                for (int n = 1; n < NCYC; n++) begin
                    @(negedge clk_fast);
                    raw_taps = raw_of(n);
                end
            end
            begin
                for (int m = 0; m <= NFRM + 1; m++) begin
                    @(posedge clk_slow);
                    #7;
                    if (m < 2) begin
                        chk("R1 R8 no record before first frame", int'(hit_valid), 0);
                    end else begin
                        bit v; int fine, ph, co;
                        expect_frame(m - 2, v, fine, ph, co);
                        chk("R3 R7 R8 R9 valid", int'(hit_valid), int'(v));
                        if (v && hit_valid) begin
                            chk("R2 R4 fine", int'(hit_fine), fine);
                            chk("R5 phase", int'(hit_phase), ph);
                            chk("R1 R6 coarse", int'(hit_coarse), co);
                        end
                    end
                end
            end
        join
        done = 1'b1;
        summary();
        $finish;
    end
endmodule